// File: doc/BRIEF.md
# Breakpoint Handshake Freeze Controller

This block sits between the handshake lines of an IP-side port and the protocol adapter logic that drives them. When breakpoint stop pulses arrive, it freezes the port. It does this by forcing every valid and accept line that goes toward the IP core to zero. The core then sees no new transfer and loses no data. Stopping the core clock alone is not enough. A handshake level that is still held while the clock stops would drop or duplicate a word.

The block reacts differently depending on the port's role and a forced mode.

- **Receiving port:** it waits until no message is open and then freezes. A request message is closed by its last-beat flag. A response message is closed by read-last.
- **Sending port:** it lets the first pulse pass with no effect. The second pulse freezes the port at once, even in the middle of a message.
- **Forced mode:** the first pulse freezes the port at once, for either role.

Once the port is frozen, an optional request asks for the core clock to be stopped. A resume input returns the port to pass-through.

The incoming stop pulse is registered once before the block acts on it. A pulse driven before clock edge k can therefore change the outputs no earlier than after edge k+1.

Top module: `hs_freeze`

## Requirements
- R1: While `rst` is high and after it falls, the block is in pass-through. Each `ip_valid_o` / `ip_accept_o` bit equals the matching adapter bit, and `core_halt_o` is 0.
- R2: A stop pulse that is high at clock edge k is first acted on at edge k+1. The outputs can therefore change no earlier than after edge k+1.
- R3: A receiving port (`role_send_i`=0) in unforced mode arms on its first pulse. It freezes at the first later edge where no request or response message is left open. Pulses still count while armed.
- R4: A request message opens on a `req_beat_i` with `req_last_i`=0 and closes on a `req_beat_i` with `req_last_i`=1. A response message opens and closes the same way, using `rsp_beat_i` and `rsp_last_i`, the read-last flag.
- R5: In unforced mode, a sending port (`role_send_i`=1) stays in pass-through after the first pulse. The second pulse freezes it at once, whether or not a message is open. A second pulse also freezes an armed receiving port at once.
- R6: With `cfg_force_i`=1, the first pulse freezes the port at once, for either role and whether or not a message is open.
- R7: While the port is frozen, further pulses are ignored. After a resume, the pulse count starts again from zero.
- R8: While the port is frozen, every bit of `ip_valid_o` and `ip_accept_o` is 0. At all other times each bit follows its adapter input within the same cycle.
- R9: `core_halt_o` is 1 exactly when the port is frozen and `cfg_core_stop_i` is 1.
- R10: `resume_i` high at an edge returns the block to pass-through. Internally the state goes from the frozen encoding 2'b10 to the idle encoding 2'b00 and the pulse count is cleared. Resume takes priority over a pulse that is acted on at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_pulse_i | input | 1 | Breakpoint stop pulse, one cycle wide |
| cfg_force_i | input | 1 | Forced mode: the first pulse freezes the port at once |
| cfg_core_stop_i | input | 1 | Allows the core clock-stop request while frozen |
| role_send_i | input | 1 | 1 = sending port, 0 = receiving port |
| resume_i | input | 1 | Return to pass-through |
| req_beat_i | input | 1 | A request beat transfers this cycle |
| req_last_i | input | 1 | That request beat ends its message |
| rsp_beat_i | input | 1 | A response beat transfers this cycle |
| rsp_last_i | input | 1 | Read-last flag on that response beat |
| adp_valid_i | input | N_VLD | Valid lines from the adapter toward the core |
| adp_accept_i | input | N_ACC | Accept lines from the adapter toward the core |
| ip_valid_o | output | N_VLD | Masked valid lines to the core |
| ip_accept_o | output | N_ACC | Masked accept lines to the core |
| core_halt_o | output | 1 | Request to stop the core clock |

## Verification
A wrong internal state shows up at the ports within the same cycle. The masked valid and accept lines and the halt request depend on the registered state only through combinational logic. A state that freezes too early, or a count that ignores the second pulse, changes the outputs one edge after the delayed pulse. A boundary tracker that loses an open message shows up as a receiving port that freezes mid-message. The bench drives toggling adapter patterns and compares the outputs on every cycle against a behavioural model, so each of these faults appears on the first cycle it matters.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_ARMED  = 2'b01,
        ST_FROZEN = 2'b10
    } freeze_st_e;

    typedef struct packed {
        logic beat;
        logic last;
    } beat_t;

    function automatic logic open_after(input logic open_now, input beat_t b);
        return b.beat ? ~b.last : open_now;
    endfunction

    function automatic logic is_frozen(input freeze_st_e s);
        return s == ST_FROZEN;
    endfunction

endpackage

// File: rtl/hsf_pulse_dly.sv
module hsf_pulse_dly (
    input  logic clk,
    input  logic rst,
    input  logic pulse_i,
    output logic pulse_q
);
    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= pulse_i;
    end
endmodule

// File: rtl/hsf_msg_track.sv
module hsf_msg_track
    import hsf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t req_i,
    input  beat_t rsp_i,
    output logic  quiet_o
);
    logic req_open, rsp_open;
    logic req_open_n, rsp_open_n;

    always_comb begin
        req_open_n = open_after(req_open, req_i);
        rsp_open_n = open_after(rsp_open, rsp_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_open <= 1'b0;
            rsp_open <= 1'b0;
        end else begin
            req_open <= req_open_n;
            rsp_open <= rsp_open_n;
        end
    end

    assign quiet_o = ~req_open_n & ~rsp_open_n;
endmodule

// File: rtl/hsf_stop_fsm.sv
module hsf_stop_fsm
    import hsf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pulse_q,
    input  logic       force_i,
    input  logic       role_send_i,
    input  logic       resume_i,
    input  logic       quiet_i,
    output freeze_st_e st_o
);
    freeze_st_e st, nxt;

    always_comb begin
        nxt = st;
        if (resume_i) begin
            nxt = ST_RUN;
        end else begin
            case (st)
                ST_RUN:    if (pulse_q) nxt = force_i ? ST_FROZEN : ST_ARMED;
                ST_ARMED:  begin
                    if (pulse_q)                        nxt = ST_FROZEN;
                    else if (!role_send_i && quiet_i)   nxt = ST_FROZEN;
                end
                ST_FROZEN: nxt = ST_FROZEN;
                default:   nxt = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_RUN;
        else     st <= nxt;
    end

    assign st_o = st;
endmodule

// File: rtl/hsf_hs_mask.sv
module hsf_hs_mask #(
    parameter int N_VLD = 2,
    parameter int N_ACC = 3
) (
    input  logic             freeze_i,
    input  logic [N_VLD-1:0] vld_i,
    input  logic [N_ACC-1:0] acc_i,
    output logic [N_VLD-1:0] vld_o,
    output logic [N_ACC-1:0] acc_o
);
    localparam int N_ALL = N_VLD + N_ACC;
    logic [N_ALL-1:0] lines_in, lines_out;

    assign lines_in = {acc_i, vld_i};

    for (genvar g = 0; g < N_ALL; g++) begin : g_lane
        assign lines_out[g] = lines_in[g] & ~freeze_i;
    end

    assign vld_o = lines_out[N_VLD-1:0];
    assign acc_o = lines_out[N_ALL-1:N_VLD];
endmodule

// File: rtl/hs_freeze.sv
module hs_freeze
    import hsf_pkg::*;
#(
    parameter int N_VLD = 2,
    parameter int N_ACC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_pulse_i,
    input  logic             cfg_force_i,
    input  logic             cfg_core_stop_i,
    input  logic             role_send_i,
    input  logic             resume_i,
    input  logic             req_beat_i,
    input  logic             req_last_i,
    input  logic             rsp_beat_i,
    input  logic             rsp_last_i,
    input  logic [N_VLD-1:0] adp_valid_i,
    input  logic [N_ACC-1:0] adp_accept_i,
    output logic [N_VLD-1:0] ip_valid_o,
    output logic [N_ACC-1:0] ip_accept_o,
    output logic             core_halt_o
);
    logic       stop_q;
    logic       quiet;
    freeze_st_e st;
    beat_t      req_b, rsp_b;
    logic       frozen;

    assign req_b = '{beat: req_beat_i, last: req_last_i};
    assign rsp_b = '{beat: rsp_beat_i, last: rsp_last_i};

    hsf_pulse_dly u_dly (
        .clk(clk), .rst(rst), .pulse_i(stop_pulse_i), .pulse_q(stop_q)
    );

    hsf_msg_track u_trk (
        .clk(clk), .rst(rst), .req_i(req_b), .rsp_i(rsp_b), .quiet_o(quiet)
    );

    hsf_stop_fsm u_fsm (
        .clk(clk), .rst(rst), .pulse_q(stop_q), .force_i(cfg_force_i),
        .role_send_i(role_send_i), .resume_i(resume_i), .quiet_i(quiet),
        .st_o(st)
    );

    assign frozen = is_frozen(st);

    hsf_hs_mask #(.N_VLD(N_VLD), .N_ACC(N_ACC)) u_mask (
        .freeze_i(frozen), .vld_i(adp_valid_i), .acc_i(adp_accept_i),
        .vld_o(ip_valid_o), .acc_o(ip_accept_o)
    );

    assign core_halt_o = frozen & cfg_core_stop_i;
endmodule

// File: rtl/hs_freeze_chk.sv
module hs_freeze_chk
    import hsf_pkg::*;
#(
    parameter int N_VLD = 2,
    parameter int N_ACC = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             stop_q,
    input logic             quiet,
    input logic             resume_i,
    input logic             role_send_i,
    input freeze_st_e       st,
    input logic [N_VLD-1:0] ip_valid_o,
    input logic [N_ACC-1:0] ip_accept_o,
    input logic             core_halt_o
);
    a_r8_frozen_masks: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FROZEN) |-> (ip_valid_o == '0 && ip_accept_o == '0));

    a_r2_leave_run_needs_pulse: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_RUN && st != ST_RUN) |-> $past(stop_q));

    a_r3_recv_freeze_on_quiet: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_ARMED && st == ST_FROZEN && !$past(role_send_i))
        |-> ($past(stop_q) || $past(quiet)));

    a_r5_send_needs_second: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_ARMED && st == ST_FROZEN && $past(role_send_i))
        |-> $past(stop_q));

    a_r10_resume_idle: assert property (@(posedge clk) disable iff (rst)
        $past(resume_i) |-> (st == ST_RUN));

    a_r7_frozen_holds: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_FROZEN && !$past(resume_i)) |-> (st == ST_FROZEN));

    a_r9_halt_only_frozen: assert property (@(posedge clk) disable iff (rst)
        core_halt_o |-> (st == ST_FROZEN));
endmodule

bind hs_freeze hs_freeze_chk #(.N_VLD(N_VLD), .N_ACC(N_ACC)) u_chk (
    .clk(clk), .rst(rst), .stop_q(stop_q), .quiet(quiet),
    .resume_i(resume_i), .role_send_i(role_send_i), .st(st),
    .ip_valid_o(ip_valid_o), .ip_accept_o(ip_accept_o),
    .core_halt_o(core_halt_o)
);

// File: tb/test_hs_freeze.sv
module test_hs_freeze;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 2;
    localparam int NA = 3;
    localparam int MAX_CYC = 5000;

    logic clk = 1'b0, rst = 1'b1;
    logic stop_i = 0, force_i = 0, cstop_i = 0, send_i = 0, resume_i = 0;
    logic qb = 0, ql = 0, sb = 0, sl = 0;
    logic [NV-1:0] av = '0;
    logic [NA-1:0] aa = '0;
    logic [NV-1:0] iv;
    logic [NA-1:0] ia;
    logic halt;

    int checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";

    // reference model state
    bit m_dly = 0, m_frozen = 0, m_qo = 0, m_so = 0;
    int m_pulses = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_freeze #(.N_VLD(NV), .N_ACC(NA)) i_hs_freeze (
        .clk(clk), .rst(rst), .stop_pulse_i(stop_i), .cfg_force_i(force_i),
        .cfg_core_stop_i(cstop_i), .role_send_i(send_i), .resume_i(resume_i),
        .req_beat_i(qb), .req_last_i(ql), .rsp_beat_i(sb), .rsp_last_i(sl),
        .adp_valid_i(av), .adp_accept_i(aa),
        .ip_valid_o(iv), .ip_accept_o(ia), .core_halt_o(halt)
    );

    always @(posedge clk) begin
        bit qo_n, so_n, quiet;
        cyc++;
        if (rst) begin
            m_dly = 0; m_frozen = 0; m_pulses = 0; m_qo = 0; m_so = 0;
        end else begin
            qo_n = qb ? !ql : m_qo;
            so_n = sb ? !sl : m_so;
            quiet = !qo_n && !so_n;
            if (resume_i) begin
                m_frozen = 0; m_pulses = 0;
            end else if (!m_frozen) begin
                if (m_dly) begin
                    m_pulses++;
                    if (force_i || m_pulses >= 2) m_frozen = 1;
                end else if (m_pulses >= 1 && !send_i && quiet) begin
                    m_frozen = 1;
                end
            end
            m_dly = stop_i; m_qo = qo_n; m_so = so_n;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        logic [NV-1:0] ev;
        logic [NA-1:0] ea;
        ev = m_frozen ? '0 : av;
        ea = m_frozen ? '0 : aa;
        checks++;
        if (iv !== ev || ia !== ea || halt !== (m_frozen && cstop_i)) begin
            errors++;
            $display("FAIL %s cycle %0d: got v=%b a=%b h=%b exp v=%b a=%b h=%b",
                     cur_req, cyc, iv, ia, halt, ev, ea, m_frozen && cstop_i);
        end
        // toggle adapter patterns so masking is visible
        av <= av + 1'b1;
        aa <= aa + 3'd3;
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic chk(bit cond, string req, string what);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: %s (v=%b a=%b h=%b)", req, what, iv, ia, halt);
        end
    endtask

    function automatic bit passing();
        return (iv == av) && (ia == aa);
    endfunction

    function automatic bit masked();
        return (iv == '0) && (ia == '0);
    endfunction

    task automatic pulse();
        stop_i = 1; tick(); stop_i = 0;
    endtask

    task automatic req_beat(bit last);
        qb = 1; ql = last; tick(); qb = 0; ql = 0;
    endtask

    task automatic rsp_beat(bit last);
        sb = 1; sl = last; tick(); sb = 0; sl = 0;
    endtask

    task automatic do_resume();
        resume_i = 1; tick(); resume_i = 0;
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run exceeded %0d cycles (expected to end)", MAX_CYC);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        cur_req = "R1";
        chk(passing() && !halt, "R1", "pass-through in reset");
        rst = 0; tick(2);
        chk(passing() && !halt, "R1", "pass-through after reset");

        // R3/R4: receiving port waits for an open request message to close
        cur_req = "R3"; send_i = 0; cstop_i = 1;
        req_beat(0);
        pulse();
        chk(passing(), "R2", "no effect one edge after the pulse");
        tick(4);
        chk(passing(), "R3", "armed receiver must wait while a request is open");
        cur_req = "R4";
        req_beat(1);
        chk(masked(), "R4", "freeze once the request closes on last beat");
        chk(halt, "R9", "halt with core-stop bit set");
        cstop_i = 0; tick();
        chk(!halt && masked(), "R9", "no halt with core-stop bit clear");

        cur_req = "R10"; do_resume(); tick();
        chk(passing(), "R10", "resume returns to pass-through");

        // R4: response closed by read-last
        cur_req = "R4";
        rsp_beat(0); pulse(); tick(3);
        chk(passing(), "R4", "open response keeps port running");
        rsp_beat(0); tick();
        chk(passing(), "R4", "non-last response beat keeps it open");
        rsp_beat(1);
        chk(masked(), "R4", "read-last closes response and freezes");
        cur_req = "R10"; do_resume(); tick();

        // R5: sending port: first pulse no effect, second immediate mid-message
        cur_req = "R5"; send_i = 1;
        pulse(); tick(5);
        chk(passing(), "R5", "first pulse leaves sending port running");
        req_beat(0);
        pulse(); tick();
        chk(masked(), "R5", "second pulse freezes sending port mid-message");
        // R7: extra pulses ignored, count restarts after resume
        cur_req = "R7";
        pulse(); tick(2); pulse(); tick(2);
        chk(masked(), "R7", "extra pulses keep port frozen");
        do_resume(); req_beat(1); tick();
        pulse(); tick(3);
        chk(passing(), "R7", "count restarted: one pulse after resume no effect");
        pulse(); tick();
        chk(masked(), "R7", "second pulse after resume freezes");
        cur_req = "R10"; do_resume(); tick();

        // R5: second pulse also freezes an armed receiver at once
        cur_req = "R5"; send_i = 0;
        req_beat(0); pulse(); tick(2);
        chk(passing(), "R5", "armed receiver waits with open request");
        pulse(); tick();
        chk(masked(), "R5", "second pulse freezes receiver mid-message");
        cur_req = "R10"; do_resume(); req_beat(1); tick();

        // R6: forced mode, open message, both roles
        cur_req = "R6"; force_i = 1;
        req_beat(0); pulse();
        chk(passing(), "R2", "forced: still running one edge after pulse");
        tick();
        chk(masked(), "R6", "forced receiver freezes on first pulse");
        do_resume(); tick();
        send_i = 1; pulse(); tick();
        chk(masked(), "R6", "forced sender freezes on first pulse");

        // R10: resume wins over a pulse acted on at the same edge
        cur_req = "R10";
        do_resume(); tick();
        stop_i = 1; tick(); stop_i = 0;
        resume_i = 1; tick(); resume_i = 0; tick(2);
        chk(passing(), "R10", "resume beats simultaneous delayed pulse");
        force_i = 0; req_beat(1); tick(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule